// File: doc/BRIEF.md
# Interrupt Status and Mask Register Group

This block gathers single-cycle event pulses from a controller into sticky status bits and turns them into one level-sensitive interrupt line. Each status bit stays set until software writes a 1 to it. Whether a set status bit can raise the interrupt depends on a mask register. Software cannot write the mask register directly. A write of 1s to a separate enable register unmasks the selected sources, and a write of 1s to a separate disable register masks them again. This lets independent software agents change individual sources without a read-modify-write race.

Only a fixed subset of bit positions is implemented. With the defaults these are bits 0 to 14 and bit 31. All other positions read as zero and ignore writes and events. The source bits are: 0 program complete, 1 program refused, 2 row read complete, 3 row read refused, and 31 bus target error. After reset every implemented source is masked. The interrupt output is registered, so it follows status and mask changes one clock later.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x00000000, the mask register reads 0x80007FFF and irq_o is low.
- R2: An event pulse on an implemented bit sets that status bit, and the bit stays set in later cycles without further events. Event pulses on unimplemented bits (30:15) leave the status reading zero.
- R3: A write to the status register (word select 0) clears exactly the implemented status bits written as 1. Bits written 0 keep their value.
- R4: When an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit is set afterwards.
- R5: A write to the enable register (word select 2) clears the mask bits written as 1 and leaves the other mask bits unchanged.
- R6: A write to the disable register (word select 3) sets the implemented mask bits written as 1. Unimplemented mask bits stay zero.
- R7: A write to the mask register address (word select 1) has no effect on the mask.
- R8: Reads of the enable and disable registers return zero.
- R9: irq_o is high exactly when, one cycle earlier, some status bit was set whose mask bit was clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one per status bit |
| bus_we_i | input | 1 | Register write strobe |
| bus_waddr_i | input | 2 | Write word select: 0 status, 1 mask, 2 enable, 3 disable |
| bus_wdata_i | input | 32 | Write data |
| bus_raddr_i | input | 2 | Read word select, same encoding as writes |
| bus_rdata_o | output | 32 | Read data, combinational from the selected register |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit register width and the implemented set 0x80007FFF. At this size a sweep can pulse every one of the 32 event positions in turn and, for each implemented one, walk the full cycle of set, masked hold, unmask, interrupt, clear and remask. The reserved positions and the one-cycle interrupt lag are checked on each step. Multi-bit patterns, an event that collides with a clear, and writes to the read-only mask address complete the coverage.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS  = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_ENABLE  = 2'd2,
    SEL_DISABLE = 2'd3
  } reg_sel_e;

  // Sticky status update: a new event takes precedence over a clear.
  function automatic logic [31:0] sticky_next(input logic [31:0] cur,
                                              input logic [31:0] clr,
                                              input logic [31:0] set,
                                              input logic [31:0] impl);
    sticky_next = ((cur & ~clr) | set) & impl;
  endfunction

  // Mask update from the enable (clear) and disable (set) strobes.
  function automatic logic [31:0] mask_next(input logic [31:0] cur,
                                            input logic [31:0] unmask,
                                            input logic [31:0] remask,
                                            input logic [31:0] impl);
    mask_next = ((cur & ~unmask) | remask) & impl;
  endfunction

  // Sources that are set and allowed through.
  function automatic logic [31:0] pending_vec(input logic [31:0] st,
                                              input logic [31:0] mk);
    pending_vec = st & ~mk;
  endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned     DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h8000_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt,
  input  logic [DATA_W-1:0] clr,
  output logic [DATA_W-1:0] status_q
);

  logic [DATA_W-1:0] status_d;

  always_comb begin
    status_d = sticky_next(status_q, clr, evt, IMPL_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= status_d;
    end
  end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned     DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h8000_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] unmask,
  input  logic [DATA_W-1:0] remask,
  output logic [DATA_W-1:0] mask_q
);

  logic [DATA_W-1:0] mask_d;

  always_comb begin
    mask_d = mask_next(mask_q, unmask, remask, IMPL_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= IMPL_MASK;
    end else begin
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] status_q,
  input  logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    unique case (reg_sel_e'(sel))
      SEL_STATUS: rdata = status_q;
      SEL_MASK:   rdata = mask_q;
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h8000_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              bus_we_i,
  input  logic [SEL_W-1:0]  bus_waddr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [SEL_W-1:0]  bus_raddr_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  // Decoded write strobes, brought out for the checker.
  logic              wr_status;
  logic              wr_enable;
  logic              wr_disable;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] unmask_vec;
  logic [DATA_W-1:0] remask_vec;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] pend_vec;
  logic              irq_q;

  always_comb begin
    wr_status  = bus_we_i && (reg_sel_e'(bus_waddr_i) == SEL_STATUS);
    wr_enable  = bus_we_i && (reg_sel_e'(bus_waddr_i) == SEL_ENABLE);
    wr_disable = bus_we_i && (reg_sel_e'(bus_waddr_i) == SEL_DISABLE);
    clr_vec    = wr_status  ? bus_wdata_i : '0;
    unmask_vec = wr_enable  ? bus_wdata_i : '0;
    remask_vec = wr_disable ? bus_wdata_i : '0;
  end

  irq_status_bank #(
    .DATA_W    (DATA_W),
    .IMPL_MASK (IMPL_MASK)
  ) i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_i),
    .clr      (clr_vec),
    .status_q (status_q)
  );

  irq_mask_bank #(
    .DATA_W    (DATA_W),
    .IMPL_MASK (IMPL_MASK)
  ) i_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .unmask (unmask_vec),
    .remask (remask_vec),
    .mask_q (mask_q)
  );

  irq_read_mux #(
    .DATA_W (DATA_W)
  ) i_rmux (
    .sel      (bus_raddr_i),
    .status_q (status_q),
    .mask_q   (mask_q),
    .rdata    (bus_rdata_o)
  );

  always_comb begin
    pend_vec = pending_vec(status_q, mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |pend_vec;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'h8000_7FFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] evt_i,
  input logic              wr_status,
  input logic              wr_enable,
  input logic              wr_disable,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq_o
);

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(evt_i & IMPL_MASK)) == $past(evt_i & IMPL_MASK))); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> ((status_q & $past(bus_wdata_i & ~evt_i)) == '0)); // R3

  AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status |=> ((status_q & $past(status_q)) == $past(status_q))); // R2

  AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> ((mask_q & $past(bus_wdata_i)) == '0)); // R5

  AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disable |=> ((mask_q & $past(bus_wdata_i & IMPL_MASK)) == $past(bus_wdata_i & IMPL_MASK))); // R6

  AST_MASK_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_enable || wr_disable) |=> $stable(mask_q)); // R7

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status_q & ~mask_q)))); // R9

endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .DATA_W    (DATA_W),
  .IMPL_MASK (IMPL_MASK)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_i),
  .wr_status   (wr_status),
  .wr_enable   (wr_enable),
  .wr_disable  (wr_disable),
  .bus_wdata_i (bus_wdata_i),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .irq_o       (irq_o)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;

  localparam int CLK_P = 10;
  localparam logic [31:0] IMPL = (32'h1 << 31) | ((32'h1 << 15) - 32'h1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic        bus_we_i = 1'b0;
  logic [1:0]  bus_waddr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [1:0]  bus_raddr_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_st = '0;
  logic [31:0] exp_mk = IMPL;

  always #(CLK_P/2) clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .bus_we_i    (bus_we_i),
    .bus_waddr_i (bus_waddr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_raddr_i (bus_raddr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    bus_raddr_i = sel;
    #1;
    check32(tag, bus_rdata_o, exp);
  endtask

  // One operation, then one idle cycle. Inputs change on falling edges.
  task automatic step(input string tag, input logic [31:0] ev, input logic we,
                      input logic [1:0] sel, input logic [31:0] d);
    logic prev_irq;
    prev_irq = |(exp_st & ~exp_mk);
    evt_i = ev; bus_we_i = we; bus_waddr_i = sel; bus_wdata_i = d;
    @(negedge clk);
    evt_i = '0; bus_we_i = 1'b0; bus_wdata_i = '0;
    if (we && sel == 2'd0) exp_st = exp_st & ~d;
    exp_st = (exp_st | ev) & IMPL;
    if (we && sel == 2'd2) exp_mk = exp_mk & ~d;
    if (we && sel == 2'd3) exp_mk = (exp_mk | d) & IMPL;
    check32({tag, " R9 lag"}, {31'b0, irq_o}, {31'b0, prev_irq});
    @(negedge clk);
    check32({tag, " R9 irq"}, {31'b0, irq_o}, {31'b0, |(exp_st & ~exp_mk)});
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd("R1 status", 2'd0, 32'h0);
    rd("R1 mask", 2'd1, 32'h8000_7FFF);
    check32("R1 irq", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep every event position through its full life cycle.
    for (int b = 0; b < 32; b++) begin
      logic [31:0] one;
      one = 32'h1 << b;
      step("R2 set", one, 1'b0, 2'd0, '0);
      step("R2 hold", '0, 1'b0, 2'd0, '0);
      rd("R2 status", 2'd0, exp_st);
      if (IMPL[b]) begin
        step("R5 unmask", '0, 1'b1, 2'd2, one);
        rd("R5 mask", 2'd1, exp_mk);
        step("R3 clear", '0, 1'b1, 2'd0, one);
        rd("R3 status", 2'd0, exp_st);
        step("R6 remask", '0, 1'b1, 2'd3, one);
        rd("R6 mask", 2'd1, exp_mk);
      end
    end

    // R3 partial clear with multi-bit pattern.
    step("R2 multi", 32'hFFFF_FFFF, 1'b0, 2'd0, '0);
    rd("R2 reserved zero", 2'd0, 32'h8000_7FFF);
    step("R3 partial", '0, 1'b1, 2'd0, 32'h0000_5A0F);
    rd("R3 partial status", 2'd0, 32'h8000_25F0);

    // R4 event collides with clear.
    step("R4 collide", 32'h0000_0003, 1'b1, 2'd0, 32'h0000_0003);
    rd("R4 status", 2'd0, 32'h8000_25F3);

    // R7 write to mask address ignored.
    step("R7 mask write", '0, 1'b1, 2'd1, 32'h0);
    rd("R7 mask", 2'd1, 32'h8000_7FFF);
    check32("R7 irq", {31'b0, irq_o}, 32'h0);

    // R5/R6 patterns, including unimplemented bits.
    step("R5 pattern", '0, 1'b1, 2'd2, 32'hFFFF_00F0);
    rd("R5 pattern mask", 2'd1, 32'h0000_7F0F);
    step("R6 pattern", '0, 1'b1, 2'd3, 32'h7FFF_0000);
    rd("R6 pattern mask", 2'd1, 32'h0000_7F0F);
    step("R6 pattern2", '0, 1'b1, 2'd3, 32'h0000_00F0);
    rd("R6 pattern2 mask", 2'd1, 32'h0000_7FFF);

    // R8 enable/disable read as zero.
    rd("R8 enable read", 2'd2, 32'h0);
    rd("R8 disable read", 2'd3, 32'h0);

    // R9: unmask bit 31 with bit 31 set.
    step("R9 unmask31", '0, 1'b1, 2'd2, 32'h8000_0000);
    check32("R9 irq high", {31'b0, irq_o}, 32'h1);
    step("R9 clear all", '0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    check32("R9 irq low", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule